// File: doc/BRIEF.md
# LPC I/O Burst Engine

This block is a host-side controller for byte-wide I/O cycles on a Low Pin Count bus. Software programs a small register set through a plain 32-bit register port: a byte count, a command (direction and address mode) and a 16-bit port address. For a write burst it also fills an outgoing byte queue. It then sets a start bit. The engine runs one LPC I/O cycle per byte on the four-bit multiplexed bus with its framing strobe. It either steps the port address by one after each byte or keeps it fixed. Returned bytes go into an incoming byte queue, which software drains after the burst.

Completion is reported as two separate status flags, idle and finished. Software can therefore tell a burst that ended successfully from one that was aborted. A burst is aborted by a target error, by an over-long wait, or by a lack of outgoing data. Inside the block, both byte queues use a valid/ready handshake. A byte moves only on a cycle where valid and ready are both high. The outgoing queue is never popped while it is empty. Pushes into a full queue are refused. The incoming queue cannot overrun, because a burst never holds more bytes than the queue does and the queue is emptied when each burst starts. The LPC clock is the block clock.

Top module: `lpc_burst_host`

## Requirements
- R1: After reset, the status register reads 0x1 (idle=1, finished=0), `lframe_n` is high and `lad_oe` is low.
- R2: The register offsets are as follows.
  - 0x00 start: writing bit 0 = 1 launches a burst.
  - 0x04 status: bit 0 is idle, bit 1 is finished.
  - 0x10 count: bits [4:0], read back.
  - 0x14 command: bit 0 selects the direction (1 = write, 0 = read) and bit 3 selects a fixed address. Other bits read as 0.
  - 0x20 port address: bits [15:0], read back.
  - 0x24: a write pushes byte [7:0] into the outgoing queue.
  - 0x28: a read pops the incoming queue.
  - A read returns its data one clock after `reg_rd_en`, with `reg_rvalid` high.
- R3: Each byte cycle has the following sequence on the bus.
  - A start clock: `lframe_n` low for exactly one clock, LAD=0000.
  - The cycle type: 0000 for a read, 0010 for a write.
  - Four address nibbles, most significant first.
  - For a write only: the data, low nibble first.
  - One host-driven 1111 clock, then one released clock.
  - After that, the target's SYNC code is sampled.
- R4: With command bit 3 clear, byte k of a burst uses address base+k. With it set, every byte uses the base address.
- R5: SYNC 0000 means ready. A read then takes the data over the next two clocks, low nibble first, and the bytes are popped from 0x28 in cycle order. Every cycle ends with two turnaround clocks.
- R6: SYNC 0101 or 0110 means wait. Up to 256 wait clocks are tolerated per cycle. The 257th wait aborts the burst: idle=1, finished=0, and the bus is released.
- R7: SYNC 1010, or any code not listed above, aborts the burst at once. No further cycle of that burst is started.
- R8: A burst whose cycles all end ready sets finished=1 and idle=1. Starting a burst clears finished.
- R9: A start with a count of 0 or above 16 runs no cycle and leaves idle=1, finished=0.
- R10: A write burst that finds the outgoing queue empty when a cycle is due aborts before that cycle (finished=0). The cycles before it complete.
- R11: While a burst is running, writes to start, count, command, address and the outgoing queue are ignored.
- R12: Each queue holds 16 bytes. A push into a full outgoing queue is dropped. The incoming queue is emptied when a burst starts. The outgoing queue is emptied when a burst ends. Reading 0x28 with the incoming queue empty returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and LPC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one clock after reg_rd_en |
| lframe_n | output | 1 | Active-low cycle framing strobe |
| lad_o | output | 4 | Multiplexed address/data nibble driven by the host |
| lad_oe | output | 1 | Host drive enable for lad_o |
| lad_i | input | 4 | Multiplexed nibble returned by the target |

## Verification
A burst sequencer that loses its place in the burst appears on the bus within one byte cycle, about 13 clocks. The symptom is an extra start clock, a missing start clock, or a wrong address nibble. A stale wait counter or a wrong SYNC decode appears as an idle/finished pair that contradicts the SYNC codes the target returned. This is visible as soon as the status is polled. A queue pointer error appears as wrong or misordered bytes, either on the bus during a write or at offset 0x28 after a read. The bench therefore compares every byte cycle seen on the bus against a queue of expected cycles, and compares every popped byte against the bytes the target model supplied.

// File: rtl/lpc_burst_pkg.sv
`timescale 1ns/1ps
package lpc_burst_pkg;
  localparam logic [7:0] A_START  = 8'h00;
  localparam logic [7:0] A_STATUS = 8'h04;
  localparam logic [7:0] A_COUNT  = 8'h10;
  localparam logic [7:0] A_CMD    = 8'h14;
  localparam logic [7:0] A_ADDR   = 8'h20;
  localparam logic [7:0] A_WFIFO  = 8'h24;
  localparam logic [7:0] A_RFIFO  = 8'h28;

  localparam int CMD_DIR_BIT = 0;
  localparam int CMD_FIX_BIT = 3;

  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] CT_IO_RD   = 4'h0;
  localparam logic [3:0] CT_IO_WR   = 4'h2;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_SWAIT = 4'h5;
  localparam logic [3:0] SYNC_LWAIT = 4'h6;
  localparam logic [3:0] NIB_IDLE   = 4'hF;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_CTYP, PH_ADDR, PH_WDATA,
    PH_TARH, PH_SYNC, PH_RDATA, PH_TART
  } phase_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_t;
endpackage

// File: rtl/lpc_byte_fifo.sv
`timescale 1ns/1ps
// Byte queue with valid/ready on both sides. DEPTH must be a power of two.
module lpc_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wp, rp;
  logic         full;

  assign full      = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  assign in_ready  = !full;
  assign out_valid = (wp != rp);
  assign out_data  = mem[rp[PW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (in_valid && in_ready)   wp <= wp + 1'b1;
      if (out_valid && out_ready) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready && !flush) mem[wp[PW-1:0]] <= in_data;
  end
endmodule

// File: rtl/lpc_io_cycle.sv
`timescale 1ns/1ps
// One byte-wide I/O cycle on the nibble bus, launched by a one-clock go.
module lpc_io_cycle import lpc_burst_pkg::*; #(
  parameter int MAX_WAIT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        wr,
  input  logic [15:0] addr,
  input  logic [7:0]  wbyte,
  output logic        done,
  output logic        ok,
  output logic [7:0]  rbyte,
  output logic        lframe_n,
  output logic [3:0]  lad_o,
  output logic        lad_oe,
  input  logic [3:0]  lad_i
);
  localparam int WCW = $clog2(MAX_WAIT + 1);

  phase_t       phase;
  logic [1:0]   sub;
  logic         wr_q;
  logic [15:0]  addr_q;
  logic [7:0]   wbyte_q;
  logic [WCW-1:0] wcnt;
  logic         is_wait;

  assign is_wait = (lad_i == SYNC_SWAIT) || (lad_i == SYNC_LWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      sub     <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wbyte_q <= '0;
      wcnt    <= '0;
      rbyte   <= '0;
      done    <= 1'b0;
      ok      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (go) begin
          wr_q    <= wr;
          addr_q  <= addr;
          wbyte_q <= wbyte;
          phase   <= PH_START;
        end
        PH_START: phase <= PH_CTYP;
        PH_CTYP: begin
          phase <= PH_ADDR;
          sub   <= '0;
        end
        PH_ADDR: begin
          if (sub == 2'd3) begin
            phase <= wr_q ? PH_WDATA : PH_TARH;
            sub   <= '0;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        PH_WDATA: begin
          if (sub == 2'd1) begin
            phase <= PH_TARH;
            sub   <= '0;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        PH_TARH: begin
          if (sub == 2'd1) begin
            phase <= PH_SYNC;
            sub   <= '0;
            wcnt  <= '0;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        PH_SYNC: begin
          if (lad_i == SYNC_READY) begin
            phase <= wr_q ? PH_TART : PH_RDATA;
            sub   <= '0;
          end else if (is_wait && (wcnt != WCW'(MAX_WAIT))) begin
            wcnt <= wcnt + 1'b1;
          end else begin
            phase <= PH_IDLE;
            done  <= 1'b1;
            ok    <= 1'b0;
          end
        end
        PH_RDATA: begin
          if (sub == 2'd0) begin
            rbyte[3:0] <= lad_i;
            sub        <= 2'd1;
          end else begin
            rbyte[7:4] <= lad_i;
            phase      <= PH_TART;
            sub        <= '0;
          end
        end
        PH_TART: begin
          if (sub == 2'd1) begin
            phase <= PH_IDLE;
            sub   <= '0;
            done  <= 1'b1;
            ok    <= 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    lframe_n = (phase != PH_START);
    lad_oe   = 1'b0;
    lad_o    = NIB_IDLE;
    unique case (phase)
      PH_START: begin
        lad_oe = 1'b1;
        lad_o  = NIB_START;
      end
      PH_CTYP: begin
        lad_oe = 1'b1;
        lad_o  = wr_q ? CT_IO_WR : CT_IO_RD;
      end
      PH_ADDR: begin
        lad_oe = 1'b1;
        unique case (sub)
          2'd0:    lad_o = addr_q[15:12];
          2'd1:    lad_o = addr_q[11:8];
          2'd2:    lad_o = addr_q[7:4];
          default: lad_o = addr_q[3:0];
        endcase
      end
      PH_WDATA: begin
        lad_oe = 1'b1;
        lad_o  = (sub == 2'd0) ? wbyte_q[3:0] : wbyte_q[7:4];
      end
      PH_TARH: begin
        lad_oe = (sub == 2'd0);
        lad_o  = NIB_IDLE;
      end
      default: begin
        lad_oe = 1'b0;
        lad_o  = NIB_IDLE;
      end
    endcase
  end
endmodule

// File: rtl/lpc_burst_seq.sv
`timescale 1ns/1ps
// Walks a burst: one io cycle per byte, address stepping, queue traffic, status.
module lpc_burst_seq import lpc_burst_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr,
  input  logic             fixed,
  input  logic [15:0]      base,
  input  logic             wf_valid,
  input  logic [7:0]       wf_data,
  output logic             wf_pop,
  output logic             wf_flush,
  output logic             rf_push,
  output logic [7:0]       rf_data,
  output logic             rf_flush,
  output logic             io_go,
  output logic             io_wr,
  output logic [15:0]      io_addr,
  output logic [7:0]       io_wbyte,
  input  logic             io_done,
  input  logic             io_ok,
  input  logic [7:0]       io_rbyte,
  output logic             busy,
  output logic             finished
);
  seq_t             state;
  logic [CNT_W-1:0] remaining;
  logic [15:0]      cur_addr;
  logic             wr_q, fixed_q;
  logic             cnt_ok, starved, last_done;

  assign cnt_ok    = (cnt != '0) && (cnt <= CNT_W'(DEPTH));
  assign busy      = (state != SQ_IDLE);
  assign starved   = (state == SQ_ISSUE) && wr_q && !wf_valid;
  assign last_done = (state == SQ_WAIT) && io_done && (!io_ok || remaining == CNT_W'(1));

  assign io_go    = (state == SQ_ISSUE) && (!wr_q || wf_valid);
  assign io_wr    = wr_q;
  assign io_addr  = cur_addr;
  assign io_wbyte = wf_data;
  assign wf_pop   = io_go && wr_q;
  assign rf_push  = (state == SQ_WAIT) && io_done && io_ok && !wr_q;
  assign rf_data  = io_rbyte;
  assign rf_flush = start && (state == SQ_IDLE);
  assign wf_flush = (start && (state == SQ_IDLE) && !cnt_ok) || starved || last_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      remaining <= '0;
      cur_addr  <= '0;
      wr_q      <= 1'b0;
      fixed_q   <= 1'b0;
      finished  <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          finished <= 1'b0;
          if (cnt_ok) begin
            remaining <= cnt;
            cur_addr  <= base;
            wr_q      <= wr;
            fixed_q   <= fixed;
            state     <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (io_go)        state <= SQ_WAIT;
          else if (starved) state <= SQ_IDLE;
        end
        SQ_WAIT: if (io_done) begin
          if (!io_ok) begin
            state <= SQ_IDLE;
          end else if (remaining == CNT_W'(1)) begin
            state    <= SQ_IDLE;
            finished <= 1'b1;
          end else begin
            remaining <= remaining - CNT_W'(1);
            if (!fixed_q) cur_addr <= cur_addr + 16'd1;
            state <= SQ_ISSUE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpc_burst_host.sv
`timescale 1ns/1ps
module lpc_burst_host import lpc_burst_pkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_WAIT   = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rvalid,
  output logic        lframe_n,
  output logic [3:0]  lad_o,
  output logic        lad_oe,
  input  logic [3:0]  lad_i
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [CNT_W-1:0] cfg_cnt;
  logic             cfg_cmd_wr, cfg_cmd_fix;
  logic [15:0]      cfg_addr;
  logic             busy, finished, wr_ok, start;

  logic       wf_push, wf_in_ready, wf_valid, wf_pop, wf_flush;
  logic [7:0] wf_data;
  logic       rf_push, rf_in_ready, rf_valid, rf_pop, rf_flush;
  logic [7:0] rf_in_data, rf_data;

  logic        io_go, io_wr, io_done, io_ok;
  logic [15:0] io_addr;
  logic [7:0]  io_wbyte, io_rbyte;
  logic        unused_bits;

  assign unused_bits = ^{reg_wdata[31:16], wf_in_ready, rf_in_ready};

  assign wr_ok   = reg_wr_en && !busy;
  assign start   = wr_ok && (reg_addr == A_START) && reg_wdata[0];
  assign wf_push = wr_ok && (reg_addr == A_WFIFO);
  assign rf_pop  = reg_rd_en && (reg_addr == A_RFIFO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_cnt     <= '0;
      cfg_cmd_wr  <= 1'b0;
      cfg_cmd_fix <= 1'b0;
      cfg_addr    <= '0;
    end else if (wr_ok) begin
      unique case (reg_addr)
        A_COUNT: cfg_cnt <= reg_wdata[CNT_W-1:0];
        A_CMD: begin
          cfg_cmd_wr  <= reg_wdata[CMD_DIR_BIT];
          cfg_cmd_fix <= reg_wdata[CMD_FIX_BIT];
        end
        A_ADDR:  cfg_addr <= reg_wdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd_en;
      if (reg_rd_en) begin
        unique case (reg_addr)
          A_STATUS: reg_rdata <= {30'd0, finished, !busy};
          A_COUNT:  reg_rdata <= {{(32-CNT_W){1'b0}}, cfg_cnt};
          A_CMD:    reg_rdata <= {28'd0, cfg_cmd_fix, 2'b00, cfg_cmd_wr};
          A_ADDR:   reg_rdata <= {16'd0, cfg_addr};
          A_RFIFO:  reg_rdata <= rf_valid ? {24'd0, rf_data} : 32'd0;
          default:  reg_rdata <= 32'd0;
        endcase
      end
    end
  end

  lpc_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .flush(wf_flush),
    .in_valid(wf_push), .in_ready(wf_in_ready), .in_data(reg_wdata[7:0]),
    .out_valid(wf_valid), .out_ready(wf_pop), .out_data(wf_data)
  );

  lpc_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rfifo (
    .clk(clk), .rst_n(rst_n), .flush(rf_flush),
    .in_valid(rf_push), .in_ready(rf_in_ready), .in_data(rf_in_data),
    .out_valid(rf_valid), .out_ready(rf_pop), .out_data(rf_data)
  );

  lpc_burst_seq #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt(cfg_cnt),
    .wr(cfg_cmd_wr), .fixed(cfg_cmd_fix), .base(cfg_addr),
    .wf_valid(wf_valid), .wf_data(wf_data), .wf_pop(wf_pop), .wf_flush(wf_flush),
    .rf_push(rf_push), .rf_data(rf_in_data), .rf_flush(rf_flush),
    .io_go(io_go), .io_wr(io_wr), .io_addr(io_addr), .io_wbyte(io_wbyte),
    .io_done(io_done), .io_ok(io_ok), .io_rbyte(io_rbyte),
    .busy(busy), .finished(finished)
  );

  lpc_io_cycle #(.MAX_WAIT(MAX_WAIT)) u_io (
    .clk(clk), .rst_n(rst_n), .go(io_go), .wr(io_wr), .addr(io_addr),
    .wbyte(io_wbyte), .done(io_done), .ok(io_ok), .rbyte(io_rbyte),
    .lframe_n(lframe_n), .lad_o(lad_o), .lad_oe(lad_oe), .lad_i(lad_i)
  );
endmodule

// File: rtl/lpc_burst_host_chk.sv
`timescale 1ns/1ps
module lpc_burst_host_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             finished,
  input logic             lframe_n,
  input logic             lad_oe,
  input logic             rf_push,
  input logic             rf_in_ready,
  input logic [CNT_W-1:0] cfg_cnt,
  input logic             cfg_cmd_wr,
  input logic             cfg_cmd_fix,
  input logic [15:0]      cfg_addr
);
  // R1: with no burst running the bus stays released
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lframe_n && !lad_oe));

  // R3: framing strobe low for one clock only, and only with the host driving
  p_frame_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> lframe_n);
  p_frame_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> lad_oe);

  // R5: incoming queue never refuses a returned byte
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_push |-> rf_in_ready);

  // R8: finished only while idle, and cleared when a burst begins
  p_finished_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !busy);
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !finished);

  // R11: configuration frozen while a burst runs
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_cnt) && $stable(cfg_cmd_wr) &&
              $stable(cfg_cmd_fix) && $stable(cfg_addr)));
endmodule

bind lpc_burst_host lpc_burst_host_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .finished(finished),
  .lframe_n(lframe_n), .lad_oe(lad_oe), .rf_push(rf_push),
  .rf_in_ready(rf_in_ready), .cfg_cnt(cfg_cnt), .cfg_cmd_wr(cfg_cmd_wr),
  .cfg_cmd_fix(cfg_cmd_fix), .cfg_addr(cfg_addr)
);

// File: tb/lpc_burst_host_tb_top.sv
`timescale 1ns/1ps
module lpc_burst_host_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        lframe_n, lad_oe;
  logic [3:0]  lad_o;
  logic [3:0]  lad_in = 4'hF;

  int checks = 0, errors = 0;
  bit finished_run = 1'b0;

  typedef struct packed { logic wr; logic [15:0] a; logic [7:0] d; } cyc_t;
  cyc_t       exp_q[$];
  logic [7:0] rd_src[$];
  int         wait_n = 0;
  int         err_at = -1;
  int         seen = 0;

  always #2 clk = ~clk;

  lpc_burst_host dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .lframe_n(lframe_n), .lad_o(lad_o),
    .lad_oe(lad_oe), .lad_i(lad_in)
  );

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Target model and scoreboard monitor on the bus
  initial begin : target
    forever begin
      @(negedge clk);
      if (!lframe_n) begin
        logic [3:0] ct;
        logic [15:0] a;
        logic [7:0] d;
        logic wr;
        int idx;
        cyc_t e;
        chk(lad_oe && lad_o == 4'h0, "R3 start nibble", {27'd0, lad_oe, lad_o}, 32'h10);
        @(negedge clk);
        ct = lad_o;
        wr = (ct == 4'h2);
        chk(lframe_n && (ct == 4'h0 || ct == 4'h2), "R3 frame/cycle type", {27'd0, lframe_n, ct}, 32'h10);
        a = '0;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          a = {a[11:0], lad_o};
        end
        d = '0;
        if (wr) begin
          @(negedge clk); d[3:0] = lad_o;
          @(negedge clk); d[7:4] = lad_o;
        end
        @(negedge clk);
        chk(lad_oe && lad_o == 4'hF, "R3 first turnaround", {27'd0, lad_oe, lad_o}, 32'h1F);
        @(negedge clk);
        chk(!lad_oe, "R3 bus released", {31'd0, lad_oe}, 32'h0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected cycle", {15'd0, wr, a}, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(e.wr == wr && e.a == a && e.d == d, "R4 cycle dir/addr/data",
              {7'd0, wr, a, d}, {7'd0, e.wr, e.a, e.d});
        end
        idx = seen;
        seen++;
        for (int w = 0; w < wait_n; w++) begin
          @(negedge clk);
          lad_in = (w % 2 == 1) ? 4'h6 : 4'h5;
        end
        @(negedge clk);
        if (idx == err_at) begin
          lad_in = 4'hA;
          @(negedge clk);
          lad_in = 4'hF;
        end else begin
          lad_in = 4'h0;
          if (!wr) begin
            logic [7:0] b;
            b = (rd_src.size() != 0) ? rd_src.pop_front() : 8'h00;
            @(negedge clk); lad_in = b[3:0];
            @(negedge clk); lad_in = b[7:4];
          end
          @(negedge clk); lad_in = 4'hF;
          @(negedge clk); lad_in = 4'hF;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    if (!reg_rvalid) begin
      checks++; errors++;
      $display("FAIL R2 read valid actual=0 expected=1");
    end
    reg_rd_en = 1'b0;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = 32'h0;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(8'h04, st);
      if (st[0]) break;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic launch(input int cnt, input logic [31:0] cmd, input logic [15:0] a);
    wr_reg(8'h10, cnt);
    wr_reg(8'h14, cmd);
    wr_reg(8'h20, {16'd0, a});
    seen = 0;
    wr_reg(8'h00, 32'h1);
  endtask

  initial begin : main
    logic [31:0] v, st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(8'h04, v);
    chk(v == 32'h1, "R1 status after reset", v, 32'h1);
    chk(lframe_n && !lad_oe, "R1 bus idle after reset", {30'd0, lframe_n, lad_oe}, 32'h2);

    // R2 register readback
    wr_reg(8'h10, 32'h23); rd_reg(8'h10, v);
    chk(v == 32'h3, "R2 count readback", v, 32'h3);
    wr_reg(8'h14, 32'hFF); rd_reg(8'h14, v);
    chk(v == 32'h9, "R2 command readback", v, 32'h9);
    wr_reg(8'h20, 32'h1234_5678); rd_reg(8'h20, v);
    chk(v == 32'h5678, "R2 address readback", v, 32'h5678);

    // R3/R4/R8 incrementing write burst
    wait_n = 0; err_at = -1;
    for (int i = 0; i < 4; i++) begin
      wr_reg(8'h24, 32'h11 * (i + 1));
      exp_q.push_back({1'b1, 16'h02F8 + 16'(i), 8'(8'h11 * (i + 1))});
    end
    launch(4, 32'h1, 16'h02F8);
    wait_idle(st);
    chk(st == 32'h3, "R8 write burst finished", st, 32'h3);
    chk(exp_q.size() == 0, "R4 all write cycles seen", exp_q.size(), 0);

    // R4/R5 fixed-address read burst with waits
    wait_n = 2;
    rd_src = '{8'hA1, 8'hB2, 8'hC3};
    for (int i = 0; i < 3; i++) exp_q.push_back({1'b0, 16'h0060, 8'h00});
    launch(3, 32'h8, 16'h0060);
    wait_idle(st);
    chk(st == 32'h3, "R5 read burst finished", st, 32'h3);
    rd_reg(8'h28, v); chk(v == 32'hA1, "R5 read byte 0", v, 32'hA1);
    rd_reg(8'h28, v); chk(v == 32'hB2, "R5 read byte 1", v, 32'hB2);
    rd_reg(8'h28, v); chk(v == 32'hC3, "R5 read byte 2", v, 32'hC3);
    rd_reg(8'h28, v); chk(v == 32'h0, "R12 empty read queue", v, 32'h0);

    // R6 wait limit: 256 tolerated, 257 aborts
    wait_n = 256;
    rd_src = '{8'h5A};
    exp_q.push_back({1'b0, 16'h0080, 8'h00});
    launch(1, 32'h0, 16'h0080);
    wait_idle(st);
    chk(st == 32'h3, "R6 256 waits succeed", st, 32'h3);
    rd_reg(8'h28, v); chk(v == 32'h5A, "R6 byte after long wait", v, 32'h5A);
    wait_n = 257;
    exp_q.push_back({1'b0, 16'h0080, 8'h00});
    launch(1, 32'h0, 16'h0080);
    wait_idle(st);
    chk(st == 32'h1, "R6 257 waits abort", st, 32'h1);
    chk(lframe_n && !lad_oe, "R6 bus released after abort", {30'd0, lframe_n, lad_oe}, 32'h2);
    rd_src.delete();

    // R7 error SYNC on second cycle of three
    wait_n = 0; err_at = 1;
    for (int i = 0; i < 3; i++) wr_reg(8'h24, 32'h40 + i);
    exp_q.push_back({1'b1, 16'h0070, 8'h40});
    exp_q.push_back({1'b1, 16'h0071, 8'h41});
    launch(3, 32'h1, 16'h0070);
    wait_idle(st);
    chk(st == 32'h1, "R7 error aborts", st, 32'h1);
    chk(seen == 2, "R7 no cycle after error", seen, 2);
    err_at = -1;

    // R9 invalid counts
    launch(0, 32'h0, 16'h0010);
    wait_idle(st);
    chk(st == 32'h1 && seen == 0, "R9 count 0", {st[15:0], 16'(seen)}, 32'h0001_0000);
    launch(17, 32'h0, 16'h0010);
    wait_idle(st);
    chk(st == 32'h1 && seen == 0, "R9 count 17", {st[15:0], 16'(seen)}, 32'h0001_0000);

    // R10 write burst runs out of bytes
    wr_reg(8'h24, 32'hE1); wr_reg(8'h24, 32'hE2);
    exp_q.push_back({1'b1, 16'h0010, 8'hE1});
    exp_q.push_back({1'b1, 16'h0011, 8'hE2});
    launch(3, 32'h1, 16'h0010);
    wait_idle(st);
    chk(st == 32'h1 && seen == 2, "R10 starved write aborts", {st[15:0], 16'(seen)}, 32'h0001_0002);

    // R11 writes ignored while busy
    wait_n = 40;
    rd_src = '{8'h21, 8'h22};
    exp_q.push_back({1'b0, 16'h0100, 8'h00});
    exp_q.push_back({1'b0, 16'h0100, 8'h00});
    launch(2, 32'h8, 16'h0100);
    wr_reg(8'h14, 32'h1);
    wr_reg(8'h20, 32'h5555);
    wr_reg(8'h10, 32'h5);
    wr_reg(8'h00, 32'h1);
    wr_reg(8'h24, 32'h77);
    wait_idle(st);
    chk(st == 32'h3 && seen == 2, "R11 burst unchanged", {st[15:0], 16'(seen)}, 32'h0003_0002);
    rd_reg(8'h10, v); chk(v == 32'h2, "R11 count kept", v, 32'h2);
    rd_reg(8'h14, v); chk(v == 32'h8, "R11 command kept", v, 32'h8);
    rd_reg(8'h20, v); chk(v == 32'h100, "R11 address kept", v, 32'h100);

    // R12 incoming queue emptied at start
    wait_n = 0;
    rd_src = '{8'h33};
    exp_q.push_back({1'b0, 16'h0200, 8'h00});
    launch(1, 32'h0, 16'h0200);
    wait_idle(st);
    rd_reg(8'h28, v); chk(v == 32'h33, "R12 stale bytes flushed", v, 32'h33);
    rd_reg(8'h28, v); chk(v == 32'h0, "R12 only new byte", v, 32'h0);

    // R12 outgoing queue emptied at burst end
    wr_reg(8'h24, 32'h99);
    rd_src = '{8'h44};
    exp_q.push_back({1'b0, 16'h0201, 8'h00});
    launch(1, 32'h0, 16'h0201);
    wait_idle(st);
    launch(1, 32'h1, 16'h0202);
    wait_idle(st);
    chk(st == 32'h1 && seen == 0, "R12 outgoing flushed", {st[15:0], 16'(seen)}, 32'h0001_0000);

    // R12 full outgoing queue drops the 17th byte; R4 fixed write
    for (int i = 0; i < 17; i++) wr_reg(8'h24, 32'(i + 1));
    for (int i = 0; i < 16; i++) exp_q.push_back({1'b1, 16'h03F8, 8'(i + 1)});
    launch(16, 32'h9, 16'h03F8);
    wait_idle(st);
    chk(st == 32'h3 && seen == 16, "R12 sixteen-byte burst", {st[15:0], 16'(seen)}, 32'h0003_0010);
    chk(exp_q.size() == 0, "R4 fixed write cycles seen", exp_q.size(), 0);

    finished_run = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule